// File: doc/BRIEF.md
# Supply Rail Attach Debouncer

This block watches three comparator outputs on a USB supply rail and turns them into a settled attach status and two interrupt flags. The high-threshold comparator reports that the rail has risen far enough to indicate an attach. The low-threshold comparator reports that the rail is still above its release level. The over-voltage comparator reports an unsafe rail. All three pass through a two-flop synchronizer. A slow real-time strobe, one system-clock cycle wide at 32.768 kHz, paces every timer.

Detection is deliberately asymmetric. An attach is accepted only after the high comparator has stayed asserted for a programmable number of milliseconds. A release is accepted on the first synchronized sample that shows the rail below the low threshold. Over-voltage has its own short debounce, counted in raw strobe ticks, and can only be reported while an attach is in progress or present.

The block holds its configuration in registers: the attach debounce code, the over-voltage debounce code and two 3-bit threshold codes. The threshold codes are passed straight out to the analog comparators. The two interrupt flags are sticky and are cleared by write-one pulses.

Top module: `vbus_attach_debounce`

## Requirements
- R1: The attach code selects the hold time in ticks: 0 selects 0, 1 selects 330, 2 selects 660 and 3 selects 990 (10 ms steps at 33 ticks per ms). The status rises only after the synchronized high input has been held that many ticks. With code 0 it rises on the first synchronized sample.
- R2: When the status rises, the detect interrupt flag is set in the same cycle.
- R3: While the status is 1, a synchronized low input of 0 clears the status and sets the detect interrupt flag at once, with no debounce.
- R4: The over-voltage code selects the hold time in ticks: 0 selects 0, 1 selects 2, 2 selects 4 and 3 selects 8. The over-voltage flag is set once that hold time has elapsed, and only once per assertion of the comparator.
- R5: An over-voltage event is recognized only while the synchronized high input or the status is 1. Otherwise it is ignored.
- R6: Both threshold codes reset to 3'b011. A configuration write strobe loads all four configuration fields, and the threshold codes are driven out unchanged.
- R7: A debounce timer returns to zero whenever its qualifying input drops before the count completes.
- R8: Each interrupt flag stays at 1 until its clear pulse arrives. If a set and a clear occur in the same cycle, the set wins.
- R9: Each comparator input passes through two flops. With a zero hold time, the outputs change on the third rising clock edge after the raw input changes.
- R10: Timers advance only in cycles where the tick strobe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick | input | 1 | One-cycle strobe at the real-time rate |
| cmp_hi_raw | input | 1 | High-threshold comparator, 1 = rail above attach level |
| cmp_lo_raw | input | 1 | Low-threshold comparator, 1 = rail above release level |
| cmp_ovp_raw | input | 1 | Over-voltage comparator, 1 = rail too high |
| cfg_we | input | 1 | Load strobe for all configuration fields |
| cfg_attach_db | input | 2 | Attach debounce code |
| cfg_ovp_db | input | 2 | Over-voltage debounce code |
| cfg_thr_hi | input | 3 | High threshold code to load |
| cfg_thr_lo | input | 3 | Low threshold code to load |
| clr_det_irq | input | 1 | Write-one clear for the detect flag |
| clr_ovp_irq | input | 1 | Write-one clear for the over-voltage flag |
| det_status | output | 1 | Settled attach status |
| det_irq | output | 1 | Sticky detect interrupt flag |
| ovp_irq | output | 1 | Sticky over-voltage interrupt flag |
| thr_hi_code | output | 3 | High threshold code to the analog side |
| thr_lo_code | output | 3 | Low threshold code to the analog side |

## Verification
The bench sweeps all four attach codes and all four over-voltage codes. For each code it samples exactly one cycle before and at the predicted rise edge, so an off-by-one counter or a missing synchronizer stage is caught. It interrupts an attach partway through and then demands the full hold again, which exposes a timer that pauses instead of restarting. It also stalls the tick strobe to show that timers do not run on the system clock. It checks that the release path ignores the attach debounce, that over-voltage is suppressed while the rail is detached, and that a clear landing in the same cycle as a new event does not erase it.

// File: rtl/vbd_pkg.sv
package vbd_pkg;

  localparam logic [2:0] THR_RESET = 3'b011;

  typedef struct packed {
    logic [1:0] attach_db;
    logic [1:0] ovp_db;
    logic [2:0] thr_hi;
    logic [2:0] thr_lo;
  } vbd_cfg_t;

  // hold time in real-time ticks for an attach code
  function automatic int unsigned attach_ticks(input logic [1:0] code,
                                               input int unsigned step_ms,
                                               input int unsigned ticks_per_ms);
    return int'(code) * step_ms * ticks_per_ms;
  endfunction

  // hold time in real-time ticks for an over-voltage code
  function automatic int unsigned ovp_ticks(input logic [1:0] code);
    return (code == 2'd0) ? 0 : (1 << int'(code));
  endfunction

endpackage

// File: rtl/vbd_sync.sv
module vbd_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = d;
    end else begin : g_rest
      always_comb stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/vbd_debounce.sv
module vbd_debounce #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          qual,
  input  logic [CW-1:0] target,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = tick && (cnt_q < target);
    if (!qual)       cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = qual && (cnt_q >= target);

  // R7: a dropped qualifier leaves the timer at zero
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> (cnt_q == '0));

  // R10: no progress without a tick
  a_r10_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/vbd_flag.sv
module vbd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_d;

  always_comb begin
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  // R8: a new event beats a simultaneous clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  // R8: a clear alone empties the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);

endmodule

// File: rtl/vbus_attach_debounce.sv
module vbus_attach_debounce #(
  parameter int TICKS_PER_MS   = 33,
  parameter int ATTACH_STEP_MS = 10,
  parameter int OVP_MAX_TICKS  = 8,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rtc_tick,
  input  logic       cmp_hi_raw,
  input  logic       cmp_lo_raw,
  input  logic       cmp_ovp_raw,
  input  logic       cfg_we,
  input  logic [1:0] cfg_attach_db,
  input  logic [1:0] cfg_ovp_db,
  input  logic [2:0] cfg_thr_hi,
  input  logic [2:0] cfg_thr_lo,
  input  logic       clr_det_irq,
  input  logic       clr_ovp_irq,
  output logic       det_status,
  output logic       det_irq,
  output logic       ovp_irq,
  output logic [2:0] thr_hi_code,
  output logic [2:0] thr_lo_code
);

  import vbd_pkg::*;

  localparam int ATT_MAX = 3 * ATTACH_STEP_MS * TICKS_PER_MS;
  localparam int ACW     = $clog2(ATT_MAX + 1);
  localparam int OCW     = $clog2(OVP_MAX_TICKS + 1);
  localparam int NCMP    = 3;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i = rst_pipe_q[1];

  // comparator synchronizer
  logic [NCMP-1:0] cmp_s;
  logic            hi_s, lo_s, ovp_s;

  vbd_sync #(.W(NCMP), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     ({cmp_ovp_raw, cmp_lo_raw, cmp_hi_raw}),
    .q     (cmp_s)
  );
  assign hi_s  = cmp_s[0];
  assign lo_s  = cmp_s[1];
  assign ovp_s = cmp_s[2];

  // configuration registers
  vbd_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d.attach_db = cfg_attach_db;
      cfg_d.ovp_db    = cfg_ovp_db;
      cfg_d.thr_hi    = cfg_thr_hi;
      cfg_d.thr_lo    = cfg_thr_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cfg_q.attach_db <= 2'b00;
      cfg_q.ovp_db    <= 2'b00;
      cfg_q.thr_hi    <= THR_RESET;
      cfg_q.thr_lo    <= THR_RESET;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign thr_hi_code = cfg_q.thr_hi;
  assign thr_lo_code = cfg_q.thr_lo;

  // debounce targets
  logic [ACW-1:0] att_target;
  logic [OCW-1:0] ovp_target;

  always_comb begin
    att_target = ACW'(attach_ticks(cfg_q.attach_db, ATTACH_STEP_MS, TICKS_PER_MS));
    ovp_target = OCW'(ovp_ticks(cfg_q.ovp_db));
  end

  // attach path
  logic status_q, status_d;
  logic att_qual, att_done;
  logic rise_evt, fall_evt;

  assign att_qual = hi_s && !status_q;

  vbd_debounce #(.CW(ACW)) u_att_db (
    .clk    (clk),
    .rst_n  (rst_i),
    .tick   (rtc_tick),
    .qual   (att_qual),
    .target (att_target),
    .done   (att_done)
  );

  always_comb begin
    rise_evt = att_done;
    fall_evt = status_q && !lo_s;
    status_d = status_q;
    if (rise_evt)      status_d = 1'b1;
    else if (fall_evt) status_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) status_q <= 1'b0;
    else        status_q <= status_d;
  end

  assign det_status = status_q;

  // over-voltage path
  logic ovp_hold_q, ovp_hold_d;
  logic ovp_qual, ovp_done, attached;

  assign attached = hi_s || status_q;
  assign ovp_qual = ovp_s && attached && !ovp_hold_q;

  vbd_debounce #(.CW(OCW)) u_ovp_db (
    .clk    (clk),
    .rst_n  (rst_i),
    .tick   (rtc_tick),
    .qual   (ovp_qual),
    .target (ovp_target),
    .done   (ovp_done)
  );

  always_comb begin
    ovp_hold_d = ovp_hold_q;
    if (!ovp_s)        ovp_hold_d = 1'b0;
    else if (ovp_done) ovp_hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) ovp_hold_q <= 1'b0;
    else        ovp_hold_q <= ovp_hold_d;
  end

  // sticky interrupt flags
  logic [1:0] flag_set, flag_clr, flag_q;

  assign flag_set = {ovp_done, rise_evt || fall_evt};
  assign flag_clr = {clr_ovp_irq, clr_det_irq};

  for (genvar f = 0; f < 2; f++) begin : g_flag
    vbd_flag u_flag (
      .clk   (clk),
      .rst_n (rst_i),
      .set   (flag_set[f]),
      .clr   (flag_clr[f]),
      .flag  (flag_q[f])
    );
  end

  assign det_irq = flag_q[0];
  assign ovp_irq = flag_q[1];

  // R3: release takes effect on the next edge and raises the flag
  a_r3_fast_release: assert property (@(posedge clk) disable iff (!rst_i)
    (status_q && !lo_s) |=> (!status_q && det_irq));

  // R2: a rise follows a high sample and comes with the flag
  a_r2_rise_flag: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(status_q) |-> ($past(hi_s) && det_irq));

  // R5: over-voltage flag only when attached
  a_r5_ovp_attached: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(ovp_irq) |-> $past(attached));

  // R6: threshold codes move only on a write
  a_r6_thr_hold: assert property (@(posedge clk) disable iff (!rst_i)
    !cfg_we |=> ($stable(thr_hi_code) && $stable(thr_lo_code)));

endmodule

// File: tb/test_vbus_attach_debounce.sv
module test_vbus_attach_debounce;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rtc_tick;
  logic       cmp_hi_raw, cmp_lo_raw, cmp_ovp_raw;
  logic       cfg_we;
  logic [1:0] cfg_attach_db, cfg_ovp_db;
  logic [2:0] cfg_thr_hi, cfg_thr_lo;
  logic       clr_det_irq, clr_ovp_irq;
  logic       det_status, det_irq, ovp_irq;
  logic [2:0] thr_hi_code, thr_lo_code;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  vbus_attach_debounce i_vbus_attach_debounce (
    .clk           (clk),
    .rst_n         (rst_n),
    .rtc_tick      (rtc_tick),
    .cmp_hi_raw    (cmp_hi_raw),
    .cmp_lo_raw    (cmp_lo_raw),
    .cmp_ovp_raw   (cmp_ovp_raw),
    .cfg_we        (cfg_we),
    .cfg_attach_db (cfg_attach_db),
    .cfg_ovp_db    (cfg_ovp_db),
    .cfg_thr_hi    (cfg_thr_hi),
    .cfg_thr_lo    (cfg_thr_lo),
    .clr_det_irq   (clr_det_irq),
    .clr_ovp_irq   (clr_ovp_irq),
    .det_status    (det_status),
    .det_irq       (det_irq),
    .ovp_irq       (ovp_irq),
    .thr_hi_code   (thr_hi_code),
    .thr_lo_code   (thr_lo_code)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic set_cfg(input logic [1:0] a, input logic [1:0] o);
    cfg_attach_db = a;
    cfg_ovp_db    = o;
    cfg_thr_hi    = 3'd5;
    cfg_thr_lo    = 3'd2;
    cfg_we        = 1'b1;
    step(1);
    cfg_we        = 1'b0;
  endtask

  task automatic clear_det;
    clr_det_irq = 1'b1;
    step(1);
    clr_det_irq = 1'b0;
  endtask

  task automatic clear_ovp;
    clr_ovp_irq = 1'b1;
    step(1);
    clr_ovp_irq = 1'b0;
  endtask

  task automatic detach;
    cmp_hi_raw = 1'b0;
    cmp_lo_raw = 1'b0;
    step(4);
    clear_det;
    cmp_lo_raw = 1'b1;
    step(3);
  endtask

  initial begin
    rst_n = 1'b0;
    rtc_tick = 1'b1;
    cmp_hi_raw = 1'b0; cmp_lo_raw = 1'b0; cmp_ovp_raw = 1'b0;
    cfg_we = 1'b0; cfg_attach_db = 2'd0; cfg_ovp_db = 2'd0;
    cfg_thr_hi = 3'd0; cfg_thr_lo = 3'd0;
    clr_det_irq = 1'b0; clr_ovp_irq = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // reset state (R6 defaults)
    chk("R6 reset status", det_status, 0);
    chk("R6 reset det_irq", det_irq, 0);
    chk("R6 reset ovp_irq", ovp_irq, 0);
    chk("R6 reset thr_hi", thr_hi_code, 3);
    chk("R6 reset thr_lo", thr_lo_code, 3);

    set_cfg(2'd0, 2'd0);
    chk("R6 loaded thr_hi", thr_hi_code, 5);
    chk("R6 loaded thr_lo", thr_lo_code, 2);

    cmp_lo_raw = 1'b1;
    step(3);

    // R1/R2/R3/R9 sweep over all attach codes
    for (int a = 0; a < 4; a++) begin
      int t;
      t = a * 10 * 33;
      set_cfg(2'(a), 2'd0);
      cmp_hi_raw = 1'b1;
      step(2 + t);
      chk($sformatf("R1 code %0d status before", a), det_status, 0);
      chk($sformatf("R9 code %0d irq before", a), det_irq, 0);
      step(1);
      chk($sformatf("R1 code %0d status at", a), det_status, 1);
      chk($sformatf("R2 code %0d irq at", a), det_irq, 1);
      clear_det;
      chk("R8 clear det", det_irq, 0);
      step(5);
      chk("R8 det stays clear", det_irq, 0);
      // release: no debounce regardless of code
      cmp_hi_raw = 1'b0;
      cmp_lo_raw = 1'b0;
      step(2);
      chk($sformatf("R3 code %0d status before release", a), det_status, 1);
      step(1);
      chk($sformatf("R3 code %0d status released", a), det_status, 0);
      chk($sformatf("R3 code %0d irq on release", a), det_irq, 1);
      clear_det;
      cmp_lo_raw = 1'b1;
      step(3);
    end

    // R7 restart after an interrupted attach
    set_cfg(2'd1, 2'd0);
    cmp_hi_raw = 1'b1;
    step(200);
    cmp_hi_raw = 1'b0;
    step(3);
    chk("R7 no status after glitch", det_status, 0);
    cmp_hi_raw = 1'b1;
    step(2 + 330);
    chk("R7 full hold required again", det_status, 0);
    step(1);
    chk("R7 status after full hold", det_status, 1);
    detach;

    // R10 timers stall without ticks
    rtc_tick = 1'b0;
    cmp_hi_raw = 1'b1;
    step(1500);
    chk("R10 no status without ticks", det_status, 0);
    rtc_tick = 1'b1;
    step(330);
    chk("R10 status before enough ticks", det_status, 0);
    step(1);
    chk("R10 status after ticks", det_status, 1);
    detach;

    // R4 over-voltage sweep
    for (int o = 0; o < 4; o++) begin
      int t;
      t = (o == 0) ? 0 : (1 << o);
      set_cfg(2'd0, 2'(o));
      cmp_hi_raw = 1'b1;
      step(3);
      clear_det;
      cmp_ovp_raw = 1'b1;
      step(2 + t);
      chk($sformatf("R4 code %0d ovp before", o), ovp_irq, 0);
      step(1);
      chk($sformatf("R4 code %0d ovp at", o), ovp_irq, 1);
      clear_ovp;
      step(20);
      chk($sformatf("R4 code %0d single event", o), ovp_irq, 0);
      cmp_ovp_raw = 1'b0;
      step(3);
      detach;
    end

    // R5 ignored while detached
    set_cfg(2'd3, 2'd0);
    cmp_ovp_raw = 1'b1;
    step(20);
    chk("R5 ovp ignored when detached", ovp_irq, 0);
    chk("R5 status unaffected", det_status, 0);
    // attach in progress counts as attached
    cmp_hi_raw = 1'b1;
    step(3);
    chk("R5 ovp during attach in progress", ovp_irq, 1);
    chk("R5 status still pending", det_status, 0);
    cmp_ovp_raw = 1'b0;
    cmp_hi_raw = 1'b0;
    step(3);
    clear_ovp;

    // R8 set wins over a same-cycle clear
    set_cfg(2'd0, 2'd0);
    chk("R8 det clear before", det_irq, 0);
    cmp_hi_raw = 1'b1;
    step(2);
    clr_det_irq = 1'b1;
    step(1);
    clr_det_irq = 1'b0;
    chk("R8 set beats clear", det_irq, 1);
    chk("R8 status rose", det_status, 1);
    clear_det;
    chk("R8 later clear", det_irq, 0);
    detach;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got 0 expected 1 (run finished)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule